// File: doc/BRIEF.md
# Conditional Branch Decoder

This block watches an instruction byte stream, one byte per cycle in which `in_valid` is high. It recognises the conditional jump encodings: the one-byte short form with an 8-bit displacement, the escape-prefixed near form with a 16-bit or 32-bit displacement, and the jump taken when the count register is zero. It gathers the displacement bytes and evaluates the condition against the arithmetic flags. It then reports, on a one-cycle `done` pulse, whether the branch is taken, how long the instruction is and where it goes.

The address of the first opcode byte is presented on `start_addr` with that byte. The flags, the count value and the count-width mode are sampled in the same cycle as the last displacement byte. The displacement-width mode is sampled with the second byte of a near form. Any byte that does not start a recognised conditional jump finishes at once with `is_branch` low. The next valid byte after a finished instruction always starts a new one.

Top module: `jcc_decoder`

## Requirements
- R1: While reset is high and in the first cycle after it, `done`, `is_branch` and `taken` are 0.
- R2: A first byte of 0x70 to 0x7F is a short conditional jump. The next valid byte is its 8-bit displacement, and the reported length is 2.
- R3: The condition code is the low opcode nibble `n`. `n[3:1]` selects the base test: 0 OF, 1 CF, 2 ZF, 3 CF or ZF, 4 SF, 5 PF, 6 SF xor OF, 7 ZF or (SF xor OF). It is taken when the base is 1 and `n[0]` is 0, or when the base is 0 and `n[0]` is 1.
- R4: Byte 0x0F followed by 0x80 to 0x8F is a near conditional jump with the same sixteen conditions. Its displacement is 2 bytes (length 4) when `near32` is 0 and 4 bytes (length 6) when `near32` is 1, with the least significant byte first.
- R5: A first byte of 0xE3 takes one displacement byte, has length 2, and is taken exactly when `count_val[15:0]` is zero (`count32`=0) or `count_val[31:0]` is zero (`count32`=1).
- R6: For every branch, taken or not, `target` is `start_addr` plus the length plus the sign-extended displacement, modulo 2^32.
- R7: A first byte that is neither 0x0F, 0xE3 nor 0x70 to 0x7F gives `done` in the next cycle with `is_branch`=0, `taken`=0, `len`=1 and `target`=0.
- R8: Byte 0x0F followed by a byte outside 0x80 to 0x8F gives `done` with `is_branch`=0, `taken`=0, `len`=2 and `target`=0.
- R9: `done` is high for exactly the one cycle after the byte that completes an instruction. Cycles with `in_valid` low do not advance decoding, and flag values before the last byte have no effect.
- R10: A byte presented in the cycle right after an instruction's last byte is decoded as the first byte of the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_byte | input | 8 | Instruction stream byte |
| start_addr | input | 32 | Address of the byte presented when it starts an instruction |
| near32 | input | 1 | Near-form displacement width: 0 = 16 bits, 1 = 32 bits |
| count32 | input | 1 | Count width for the zero test: 0 = 16 bits, 1 = 32 bits |
| count_val | input | 32 | Count register value |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| flag_pf | input | 1 | Parity flag |
| done | output | 1 | One-cycle pulse: the results below are valid |
| is_branch | output | 1 | The finished instruction was a conditional jump |
| taken | output | 1 | Branch condition holds |
| len | output | 4 | Instruction length in bytes |
| target | output | 32 | Branch destination address |

## Verification
The bench sweeps all sixteen condition codes against every flag combination. A decoder that swapped a complement pair, or merged signed and unsigned tests, shows the wrong `taken` on some code. Displacements with the top bit set, in 8-, 16- and 32-bit widths, expose a design that zero-extends or assembles the bytes big-endian. A target near the top of the address space exposes one that fails to wrap. The count test is run with a value that is zero only in its low half, which catches a design that ignores `count32`. Gaps in `in_valid`, flags that change between displacement bytes, and an instruction that follows another with no idle cycle catch a design that samples too early or loses the first byte of the next instruction.

// File: rtl/brd_pkg.sv
package brd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ESC  = 2'd1,
    ST_DISP = 2'd2
  } brd_state_e;

  typedef enum logic [1:0] {
    KIND_SHORT = 2'd0,
    KIND_NEAR  = 2'd1,
    KIND_CNTZ  = 2'd2
  } brd_kind_e;

  localparam logic [7:0] OP_ESCAPE = 8'h0F;
  localparam logic [7:0] OP_CNTZ   = 8'hE3;
  localparam logic [3:0] HI_SHORT  = 4'h7;
  localparam logic [3:0] HI_NEAR   = 4'h8;
endpackage

// File: rtl/brd_cond_eval.sv
module brd_cond_eval (
  input  logic [3:0] cc,
  input  logic       cf,
  input  logic       zf,
  input  logic       sf,
  input  logic       of,
  input  logic       pf,
  output logic       take
);
  logic base;
  logic sgn_lt;

  assign sgn_lt = sf ^ of;

  always_comb begin
    unique case (cc[3:1])
      3'd0: base = of;
      3'd1: base = cf;
      3'd2: base = zf;
      3'd3: base = cf | zf;
      3'd4: base = sf;
      3'd5: base = pf;
      3'd6: base = sgn_lt;
      default: base = zf | sgn_lt;
    endcase
  end

  // odd codes are the complement of their even partner
  assign take = base ^ cc[0];
endmodule

// File: rtl/brd_disp_collect.sv
module brd_disp_collect #(
  parameter int MAXB = 4,
  localparam int IDX_W = $clog2(MAXB) + 1,
  localparam int RAW_W = MAXB * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       byte_in,
  input  logic [IDX_W-1:0] nbytes,
  output logic             last,
  output logic [RAW_W-1:0] disp_sext
);
  localparam int SH_W = $clog2(RAW_W + 1);

  logic [IDX_W-1:0] idx;
  logic [RAW_W-1:0] lanes_q;
  logic [RAW_W-1:0] raw_now;
  logic [SH_W-1:0]  shamt;
  logic [RAW_W-1:0] shl;

  assign last = wr_en && (idx == nbytes - IDX_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      lanes_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < MAXB; i++)
        if (idx == IDX_W'(i)) lanes_q[i*8 +: 8] <= byte_in;
      idx <= last ? '0 : idx + IDX_W'(1);
    end
  end

  // merge the byte arriving this cycle so the final lane needs no extra cycle
  generate
    for (genvar g = 0; g < MAXB; g++) begin : g_lane
      assign raw_now[g*8 +: 8] = (wr_en && idx == IDX_W'(g)) ? byte_in : lanes_q[g*8 +: 8];
    end
  endgenerate

  assign shamt     = SH_W'((MAXB - int'(nbytes)) * 8);
  assign shl       = raw_now << shamt;
  assign disp_sext = RAW_W'($signed(shl) >>> shamt);

  // R4
  lane_bound_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (idx < nbytes));
endmodule

// File: rtl/jcc_decoder.sv
module jcc_decoder #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int MAXB   = 4,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              near32,
  input  logic              count32,
  input  logic [CNT_W-1:0]  count_val,
  input  logic              flag_cf,
  input  logic              flag_zf,
  input  logic              flag_sf,
  input  logic              flag_of,
  input  logic              flag_pf,
  output logic              done,
  output logic              is_branch,
  output logic              taken,
  output logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] target
);
  import brd_pkg::*;

  localparam int IDX_W = $clog2(MAXB) + 1;
  localparam int RAW_W = MAXB * 8;
  localparam int HALF  = CNT_W / 2;

  brd_state_e        state;
  brd_kind_e         kind;
  logic [3:0]        cc_q;
  logic [IDX_W-1:0]  nbytes_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] base_q;

  logic              disp_wr;
  logic              disp_last;
  logic [RAW_W-1:0]  disp_sx;
  logic              cond_take;
  logic              cnt_zero;

  assign disp_wr  = in_valid && (state == ST_DISP);
  assign cnt_zero = count32 ? (count_val == '0) : (count_val[HALF-1:0] == '0);

  brd_cond_eval u_cond (
    .cc  (cc_q),
    .cf  (flag_cf),
    .zf  (flag_zf),
    .sf  (flag_sf),
    .of  (flag_of),
    .pf  (flag_pf),
    .take(cond_take)
  );

  brd_disp_collect #(.MAXB(MAXB)) u_disp (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (disp_wr),
    .byte_in  (in_byte),
    .nbytes   (nbytes_q),
    .last     (disp_last),
    .disp_sext(disp_sx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      kind      <= KIND_SHORT;
      cc_q      <= '0;
      nbytes_q  <= IDX_W'(1);
      len_q     <= '0;
      base_q    <= '0;
      done      <= 1'b0;
      is_branch <= 1'b0;
      taken     <= 1'b0;
      len       <= '0;
      target    <= '0;
    end else begin
      done <= 1'b0;
      if (in_valid) begin
        unique case (state)
          ST_IDLE: begin
            base_q <= start_addr;
            if (in_byte[7:4] == HI_SHORT) begin
              kind     <= KIND_SHORT;
              cc_q     <= in_byte[3:0];
              nbytes_q <= IDX_W'(1);
              len_q    <= LEN_W'(2);
              state    <= ST_DISP;
            end else if (in_byte == OP_CNTZ) begin
              kind     <= KIND_CNTZ;
              nbytes_q <= IDX_W'(1);
              len_q    <= LEN_W'(2);
              state    <= ST_DISP;
            end else if (in_byte == OP_ESCAPE) begin
              state <= ST_ESC;
            end else begin
              done      <= 1'b1;
              is_branch <= 1'b0;
              taken     <= 1'b0;
              len       <= LEN_W'(1);
              target    <= '0;
            end
          end
          ST_ESC: begin
            if (in_byte[7:4] == HI_NEAR) begin
              kind     <= KIND_NEAR;
              cc_q     <= in_byte[3:0];
              nbytes_q <= near32 ? IDX_W'(4) : IDX_W'(2);
              len_q    <= near32 ? LEN_W'(6) : LEN_W'(4);
              state    <= ST_DISP;
            end else begin
              done      <= 1'b1;
              is_branch <= 1'b0;
              taken     <= 1'b0;
              len       <= LEN_W'(2);
              target    <= '0;
              state     <= ST_IDLE;
            end
          end
          default: begin
            if (disp_last) begin
              done      <= 1'b1;
              is_branch <= 1'b1;
              taken     <= (kind == KIND_CNTZ) ? cnt_zero : cond_take;
              len       <= len_q;
              target    <= base_q + ADDR_W'(len_q) + ADDR_W'($signed(disp_sx));
              state     <= ST_IDLE;
            end
          end
        endcase
      end
    end
  end

  // R9
  done_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(in_valid));

  // R7
  nonbranch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !is_branch) |-> (!taken && target == '0));

  // R4
  len_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (done && is_branch) |-> (len == LEN_W'(2) || len == LEN_W'(4) || len == LEN_W'(6)));

  // R8
  escape_len_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(state) == ST_ESC) |-> (!is_branch && len == LEN_W'(2)));
endmodule

// File: tb/test_jcc_decoder.sv
`timescale 1ns/1ps
module test_jcc_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [31:0] start_addr = '0;
  logic        near32 = 1'b0;
  logic        count32 = 1'b0;
  logic [31:0] count_val = '0;
  logic        flag_cf = 0, flag_zf = 0, flag_sf = 0, flag_of = 0, flag_pf = 0;
  logic        done, is_branch, taken;
  logic [3:0]  len;
  logic [31:0] target;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  jcc_decoder i_jcc_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .start_addr(start_addr), .near32(near32), .count32(count32),
    .count_val(count_val), .flag_cf(flag_cf), .flag_zf(flag_zf),
    .flag_sf(flag_sf), .flag_of(flag_of), .flag_pf(flag_pf),
    .done(done), .is_branch(is_branch), .taken(taken), .len(len),
    .target(target)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_take(input logic [3:0] n, input logic [4:0] f);
    logic cf, zf, sf, of, pf;
    {cf, zf, sf, of, pf} = f;
    case (n)
      4'h0: return of;        4'h1: return !of;
      4'h2: return cf;        4'h3: return !cf;
      4'h4: return zf;        4'h5: return !zf;
      4'h6: return cf || zf;  4'h7: return !cf && !zf;
      4'h8: return sf;        4'h9: return !sf;
      4'hA: return pf;        4'hB: return !pf;
      4'hC: return sf != of;  4'hD: return sf == of;
      4'hE: return zf || (sf != of);
      default: return !zf && (sf == of);
    endcase
  endfunction

  task automatic set_flags(input logic [4:0] f);
    {flag_cf, flag_zf, flag_sf, flag_of, flag_pf} = f;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'h00;
  endtask

  task automatic expect_out(input string req, input logic br, input logic tk,
                            input logic [3:0] l, input logic [31:0] tg);
    chk(req, "done", {31'b0, done}, 32'd1);
    chk(req, "is_branch", {31'b0, is_branch}, {31'b0, br});
    chk(req, "taken", {31'b0, taken}, {31'b0, tk});
    chk(req, "len", {28'b0, len}, {28'b0, l});
    chk(req, "target", target, tg);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", {31'b0, done}, 32'd0);
    chk("R1", "is_branch in reset", {31'b0, is_branch}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "done after reset", {31'b0, done}, 32'd0);
    chk("R1", "taken after reset", {31'b0, taken}, 32'd0);
  endtask

  task automatic t_short_sweep();
    for (int n = 0; n < 16; n++) begin
      for (int f = 0; f < 32; f++) begin
        start_addr = 32'h0000_1000;
        set_flags(5'(f));
        put(8'h70 | 8'(n));
        put(8'hF0);
        idle();
        expect_out("R2 R3", 1'b1, exp_take(4'(n), 5'(f)), 4'd2, 32'h0000_0FF2);
      end
    end
  endtask

  task automatic t_short_wrap();
    start_addr = 32'hFFFF_FFF0;
    set_flags(5'b01000);
    put(8'h74);
    put(8'h7F);
    idle();
    expect_out("R6", 1'b1, 1'b1, 4'd2, 32'h0000_0071);
  endtask

  task automatic t_near();
    near32 = 1'b0;
    start_addr = 32'h0000_2000;
    set_flags(5'b01000);
    put(8'h0F); put(8'h84); put(8'h34); put(8'h12);
    idle();
    expect_out("R4 R6 16-bit", 1'b1, 1'b1, 4'd4, 32'h0000_3238);
    start_addr = 32'h0000_0100;
    set_flags(5'b00000);
    put(8'h0F); put(8'h87); put(8'hFE); put(8'hFF);
    idle();
    expect_out("R4 R6 16-bit negative", 1'b1, 1'b1, 4'd4, 32'h0000_0102);
    near32 = 1'b1;
    start_addr = 32'h0000_0010;
    set_flags(5'b00110);
    put(8'h0F); put(8'h8F); put(8'h78); put(8'h56); put(8'h34); put(8'h12);
    idle();
    expect_out("R4 R6 32-bit", 1'b1, 1'b1, 4'd6, 32'h1234_568E);
    put(8'h0F); put(8'h8C); put(8'h00); put(8'h00); put(8'h00); put(8'h80);
    idle();
    expect_out("R4 R6 32-bit negative", 1'b1, 1'b0, 4'd6, 32'h8000_0016);
    near32 = 1'b0;
  endtask

  task automatic t_count_zero();
    start_addr = 32'h0000_0040;
    count_val  = 32'h0001_0000;
    count32    = 1'b0;
    put(8'hE3); put(8'h10); idle();
    expect_out("R5 16-bit zero", 1'b1, 1'b1, 4'd2, 32'h0000_0052);
    count32 = 1'b1;
    put(8'hE3); put(8'h10); idle();
    expect_out("R5 32-bit nonzero", 1'b1, 1'b0, 4'd2, 32'h0000_0052);
    count_val = 32'h0000_0000;
    put(8'hE3); put(8'h10); idle();
    expect_out("R5 32-bit zero", 1'b1, 1'b1, 4'd2, 32'h0000_0052);
    count_val = 32'h0000_0001;
    count32   = 1'b0;
    put(8'hE3); put(8'h10); idle();
    expect_out("R5 16-bit nonzero", 1'b1, 1'b0, 4'd2, 32'h0000_0052);
  endtask

  task automatic t_non_branch();
    set_flags(5'b11111);
    put(8'h90); idle();
    expect_out("R7", 1'b0, 1'b0, 4'd1, 32'h0);
    idle();
    chk("R9", "done single cycle", {31'b0, done}, 32'd0);
    put(8'h0F); put(8'h05); idle();
    expect_out("R8", 1'b0, 1'b0, 4'd2, 32'h0);
  endtask

  task automatic t_gaps();
    near32 = 1'b0;
    start_addr = 32'h0000_0500;
    set_flags(5'b01000);
    put(8'h0F); idle(); idle();
    chk("R9", "no done during gap", {31'b0, done}, 32'd0);
    put(8'h84); idle();
    put(8'h02); idle(); idle();
    chk("R9", "no done mid displacement", {31'b0, done}, 32'd0);
    set_flags(5'b00000);
    put(8'h00); idle();
    expect_out("R9 flags sampled at last byte", 1'b1, 1'b0, 4'd4, 32'h0000_0506);
  endtask

  task automatic t_back_to_back();
    start_addr = 32'h0000_0800;
    set_flags(5'b00000);
    put(8'h75); put(8'h02);
    start_addr = 32'h0000_0802;
    put(8'h90);
    expect_out("R10 first", 1'b1, 1'b1, 4'd2, 32'h0000_0804);
    idle();
    expect_out("R10 second", 1'b0, 1'b0, 4'd1, 32'h0);
  endtask

  initial begin
    #700000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_short_sweep();
    t_short_wrap();
    t_near();
    t_count_zero();
    t_non_branch();
    t_gaps();
    t_back_to_back();
    idle();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule